// File: doc/BRIEF.md
# Halt and Interrupt Sequencing Controller

This block is the control unit of an 8-bit CPU core that decides when the core parks itself in a halted state and when it may take an interrupt. It watches the opcode-fetch strobe and fetched byte, the instruction-boundary pulse, and the decoded enable/disable strobes, and it owns the interrupt-enable flip-flop together with the copy saved when a non-maskable request is taken. When the fetched byte is the halt opcode, the core is held on that location. The block then generates its own dummy fetch cycles, each `NOP_TICKS` clocks long, which run as NOPs so that refresh keeps going. The program counter stays frozen and the active-low halt pin stays low for as long as this lasts.

Interrupts are looked at only at boundaries. In the running state a boundary is the core's `insn_done` pulse; in the halted state it is the last clock of each dummy cycle. A latched non-maskable edge always wins. A maskable request is taken only when the enable flip-flop is set and the boundary is not the one of an enable or disable instruction. The effect is that enabling lands one instruction late, and a disabled core sitting in halt can only be freed by a non-maskable request or reset. Leaving the halted state for an interrupt first gives a one-clock program-counter bump past the halt opcode, then the acknowledge.

The states are RUN (normal execution), HALT (dummy NOP cycles), STEP (one-clock PC bump after a halted acceptance) and ACK (one-clock acknowledge with kind and vector). The transitions are: RUN→ACK on acceptance at a boundary; RUN→HALT on a fetch of the halt opcode; HALT→STEP on acceptance at a dummy-cycle boundary; STEP→ACK always; ACK→RUN always; reset forces RUN from any state.

Top module: `halt_irq_seq`

## Requirements
- R1: While reset is applied and on the first clock after its release, `halt_n` is 1, `ie_flag` and `ie_copy` are 0, `ack_valid`, `pc_hold`, `pc_bump` and `nop_sub` are 0.
- R2: A `fetch_stb` in RUN carrying byte 0x76 makes `halt_n` 0 and `nop_sub` and `pc_hold` 1 from the next clock on; any other byte leaves `halt_n` at 1.
- R3: In HALT each dummy cycle lasts `NOP_TICKS` (default 4) clocks and its last clock is a boundary; with a request pending on entry, `halt_n` stays 0 for exactly `NOP_TICKS` clocks.
- R4: An acceptance in HALT gives exactly one clock with `pc_bump` 1 and `halt_n` 1, followed on the next clock by `ack_valid`.
- R5: `ei_stb` given with the `insn_done` of the enabling instruction sets `ie_flag`, but no maskable request is accepted at that boundary; one pending at the next boundary is accepted.
- R6: `di_stb` with `insn_done` clears `ie_flag` and blocks a maskable request at that boundary; with `ie_flag` 0 a low `irq_n` produces no acknowledge and a halted core stays halted.
- R7: A rising edge on `nmi` is latched until taken at a later boundary regardless of `ie_flag`; the acknowledge carries `ack_nmi` 1 and vector 0x0066, `ie_copy` receives the prior `ie_flag` and `ie_flag` is cleared.
- R8: When a latched non-maskable edge and an enabled maskable request meet at the same boundary, the non-maskable one is taken.
- R9: A maskable acceptance gives `ack_nmi` 0 and vector 0x0038, and clears `ie_flag`.
- R10: An acceptance in RUN raises `ack_valid` on the clock after the boundary, for one clock, with no `pc_bump`.
- R11: Reset applied while halted returns `halt_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_stb | input | 1 | Opcode fetch strobe |
| fetch_op | input | 8 | Fetched opcode byte |
| insn_done | input | 1 | Instruction-boundary pulse from the core |
| ei_stb | input | 1 | Decoded enable-interrupts strobe, given with insn_done |
| di_stb | input | 1 | Decoded disable-interrupts strobe, given with insn_done |
| irq_n | input | 1 | Maskable interrupt request, active low, level |
| nmi | input | 1 | Non-maskable request, rising edge |
| halt_n | output | 1 | Halted indication, active low |
| nop_sub | output | 1 | Execute fetched byte as NOP |
| pc_hold | output | 1 | Inhibit PC increment |
| pc_bump | output | 1 | Advance PC by one (step over halt opcode) |
| ack_valid | output | 1 | Interrupt acknowledge request |
| ack_nmi | output | 1 | Acknowledge kind: 1 non-maskable, 0 maskable |
| ack_vec | output | 16 | Entry address for the acknowledge |
| ie_flag | output | 1 | Interrupt-enable flip-flop |
| ie_copy | output | 1 | Enable flip-flop copy saved on non-maskable entry |

## Verification
A boundary in RUN takes effect one clock later: the ACK state, or the cleared or set `ie_flag`, is visible on the clock after the `insn_done` clock. A halt fetch shows on the next clock, the first halted boundary falls `NOP_TICKS` clocks after entry, the PC bump sits on the clock after it and the acknowledge one clock after that. The bench drives every input on falling edges and reads outputs on the falling edge after the rising edge that must have produced them. Expected acknowledges go into a queue ahead of time with their kind, vector and whether a bump must precede them, and a monitor matches each acknowledge as it appears and flags any that was not expected.

// File: rtl/hisq_pkg.sv
package hisq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2,
        ST_ACK  = 2'd3
    } hisq_state_t;

    localparam logic [7:0]  HALT_OPCODE = 8'h76;
    localparam logic [15:0] VEC_NMI     = 16'h0066;
    localparam logic [15:0] VEC_IRQ     = 16'h0038;
endpackage

// File: rtl/hisq_nmi_latch.sv
module hisq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic taken,
    output logic pending
);
    logic nmi_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            pending  <= (pending & ~taken) | (nmi_in & ~nmi_prev);
        end
    end
endmodule

// File: rtl/hisq_nop_timer.sv
module hisq_nop_timer #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last_tick
);
    localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign last_tick = active && (cnt == LAST);
endmodule

// File: rtl/hisq_enable_ff.sv
module hisq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic take_nmi,
    input  logic take_any,
    output logic ie,
    output logic ie_saved
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie       <= 1'b0;
            ie_saved <= 1'b0;
        end else begin
            if (take_nmi)
                ie_saved <= ie;
            if (take_any || clr_en)
                ie <= 1'b0;
            else if (set_en)
                ie <= 1'b1;
        end
    end
endmodule

// File: rtl/halt_irq_seq.sv
module halt_irq_seq
    import hisq_pkg::*;
#(
    parameter int NOP_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_stb,
    input  logic [7:0]  fetch_op,
    input  logic        insn_done,
    input  logic        ei_stb,
    input  logic        di_stb,
    input  logic        irq_n,
    input  logic        nmi,
    output logic        halt_n,
    output logic        nop_sub,
    output logic        pc_hold,
    output logic        pc_bump,
    output logic        ack_valid,
    output logic        ack_nmi,
    output logic [15:0] ack_vec,
    output logic        ie_flag,
    output logic        ie_copy
);
    hisq_state_t state, state_nx;
    logic kind_nmi_q;
    logic nmi_pend, t_last;
    logic in_run, boundary, en_block;
    logic take_nmi, take_irq, take_any;

    assign in_run   = (state == ST_RUN);
    assign boundary = (in_run && insn_done) || (state == ST_HALT && t_last);
    assign en_block = in_run && (ei_stb || di_stb);
    assign take_nmi = boundary && nmi_pend;
    assign take_irq = boundary && !nmi_pend && ie_flag && !irq_n && !en_block;
    assign take_any = take_nmi || take_irq;

    hisq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi),
        .taken   (take_nmi),
        .pending (nmi_pend)
    );

    hisq_nop_timer #(.TICKS(NOP_TICKS)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state == ST_HALT),
        .last_tick (t_last)
    );

    hisq_enable_ff u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (in_run && insn_done && ei_stb),
        .clr_en   (in_run && insn_done && di_stb),
        .take_nmi (take_nmi),
        .take_any (take_any),
        .ie       (ie_flag),
        .ie_saved (ie_copy)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (take_any)
                    state_nx = ST_ACK;
                else if (fetch_stb && fetch_op == HALT_OPCODE)
                    state_nx = ST_HALT;
            end
            ST_HALT: if (take_any) state_nx = ST_STEP;
            ST_STEP: state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    // state register and acknowledge kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            kind_nmi_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_any)
                kind_nmi_q <= take_nmi;
        end
    end

    // outputs from state
    always_comb begin
        halt_n    = 1'b1;
        nop_sub   = 1'b0;
        pc_hold   = 1'b0;
        pc_bump   = 1'b0;
        ack_valid = 1'b0;
        ack_nmi   = 1'b0;
        ack_vec   = 16'h0000;
        unique case (state)
            ST_RUN: ;
            ST_HALT: begin
                halt_n  = 1'b0;
                nop_sub = 1'b1;
                pc_hold = 1'b1;
            end
            ST_STEP: pc_bump = 1'b1;
            ST_ACK: begin
                ack_valid = 1'b1;
                ack_nmi   = kind_nmi_q;
                ack_vec   = kind_nmi_q ? VEC_NMI : VEC_IRQ;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hisq_checker.sv
module hisq_checker (
    input logic clk,
    input logic rst_n,
    input logic halt_n,
    input logic nop_sub,
    input logic pc_hold,
    input logic pc_bump,
    input logic ack_valid,
    input logic ie_flag
);
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |-> (pc_hold && nop_sub && !pc_bump)); // R2

    AST_EXIT_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_n) |-> pc_bump); // R4

    AST_BUMP_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pc_bump |=> ack_valid); // R4

    AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !ie_flag); // R9

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R10
endmodule

bind halt_irq_seq hisq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_n    (halt_n),
    .nop_sub   (nop_sub),
    .pc_hold   (pc_hold),
    .pc_bump   (pc_bump),
    .ack_valid (ack_valid),
    .ie_flag   (ie_flag)
);

// File: tb/sim_halt_irq_seq.sv
`timescale 1ns/1ps
module sim_halt_irq_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_stb = 1'b0;
    logic [7:0] fetch_op = 8'h00;
    logic insn_done = 1'b0, ei_stb = 1'b0, di_stb = 1'b0;
    logic irq_n = 1'b1, nmi = 1'b0;
    logic halt_n, nop_sub, pc_hold, pc_bump, ack_valid, ack_nmi, ie_flag, ie_copy;
    logic [15:0] ack_vec;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct packed { logic nmi; logic [15:0] vec; logic bumped; } exp_t;
    exp_t exp_q[$];
    logic prev_bump = 1'b0;

    always #2.5 clk = ~clk;

    halt_irq_seq u0 (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .fetch_op(fetch_op),
        .insn_done(insn_done), .ei_stb(ei_stb), .di_stb(di_stb),
        .irq_n(irq_n), .nmi(nmi), .halt_n(halt_n), .nop_sub(nop_sub),
        .pc_hold(pc_hold), .pc_bump(pc_bump), .ack_valid(ack_valid),
        .ack_nmi(ack_nmi), .ack_vec(ack_vec), .ie_flag(ie_flag), .ie_copy(ie_copy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: match each acknowledge against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected ack", ack_vec, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(ack_nmi == e.nmi, "R8 ack kind", ack_nmi, e.nmi);
                    chk(ack_vec == e.vec, "R7/R9 ack vector", ack_vec, e.vec);
                    chk(prev_bump == e.bumped, "R4/R10 bump before ack", prev_bump, e.bumped);
                end
            end
            prev_bump <= pc_bump;
        end else begin
            prev_bump <= 1'b0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse(input logic e, input logic d);
        @(negedge clk); insn_done = 1'b1; ei_stb = e; di_stb = d;
        @(negedge clk); insn_done = 1'b0; ei_stb = 1'b0; di_stb = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] op);
        @(negedge clk); fetch_stb = 1'b1; fetch_op = op;
        @(negedge clk); fetch_stb = 1'b0;
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        tick(2);
        chk(halt_n == 1 && ack_valid == 0, "R1 during reset", halt_n, 1);
        rst_n = 1'b1;
        tick(1);
        chk(halt_n && !ie_flag && !ie_copy && !ack_valid && !pc_hold && !pc_bump && !nop_sub,
            "R1 after reset", {halt_n, ie_flag, pc_hold}, 3'b100);

        // R2: non-halt opcode leaves core running
        fetch(8'h3E);
        chk(halt_n == 1, "R2 other opcode", halt_n, 1);

        // R5/R9/R10: enable lands one instruction late
        irq_n = 1'b0;
        done_pulse(1'b1, 1'b0);
        chk(ie_flag == 1, "R5 ie set", ie_flag, 1);
        chk(ack_valid == 0, "R5 no ack at enable boundary", ack_valid, 0);
        exp_q.push_back('{nmi: 1'b0, vec: 16'h0038, bumped: 1'b0});
        done_pulse(1'b0, 1'b0);
        chk(ack_valid == 1, "R10 ack one clock after boundary", ack_valid, 1);
        irq_n = 1'b1;
        tick(1);
        chk(ie_flag == 0, "R9 ie cleared", ie_flag, 0);

        // R2/R6/R7: disabled halt, maskable ignored, NMI frees it
        fetch(8'h76);
        chk(halt_n == 0 && nop_sub && pc_hold, "R2 halt entry", {halt_n, nop_sub, pc_hold}, 3'b011);
        irq_n = 1'b0;
        tick(24);
        chk(halt_n == 0, "R6 stays halted", halt_n, 0);
        irq_n = 1'b1;
        exp_q.push_back('{nmi: 1'b1, vec: 16'h0066, bumped: 1'b1});
        nmi_pulse();
        tick(10);
        chk(halt_n == 1, "R7 nmi releases", halt_n, 1);
        chk(ie_copy == 0 && ie_flag == 0, "R7 saved copy", ie_copy, 0);

        // R3/R4: dummy cycle length and bump timing
        done_pulse(1'b1, 1'b0);
        done_pulse(1'b0, 1'b0);
        fetch(8'h76);
        irq_n = 1'b0;
        exp_q.push_back('{nmi: 1'b0, vec: 16'h0038, bumped: 1'b1});
        chk(halt_n == 0, "R3 halted", halt_n, 0);
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk(halt_n == 0 && pc_bump == 0, "R3 within dummy cycle", halt_n, 0);
        end
        tick(1);
        chk(pc_bump == 1 && halt_n == 1, "R4 bump clock", {pc_bump, halt_n}, 2'b11);
        tick(1);
        chk(ack_valid == 1 && pc_bump == 0, "R4 ack after bump", ack_valid, 1);
        irq_n = 1'b1;
        tick(1);

        // R8: priority
        done_pulse(1'b1, 1'b0);
        done_pulse(1'b0, 1'b0);
        fetch(8'h76);
        irq_n = 1'b0;
        exp_q.push_back('{nmi: 1'b1, vec: 16'h0066, bumped: 1'b1});
        nmi_pulse();
        tick(10);
        chk(ie_copy == 1 && ie_flag == 0, "R8 nmi won, copy kept", {ie_copy, ie_flag}, 2'b10);
        done_pulse(1'b0, 1'b0);
        tick(2);
        irq_n = 1'b1;

        // R6: disable blocks at its own boundary
        done_pulse(1'b1, 1'b0);
        done_pulse(1'b0, 1'b0);
        irq_n = 1'b0;
        done_pulse(1'b0, 1'b1);
        chk(ack_valid == 0 && ie_flag == 0, "R6 disable boundary", {ack_valid, ie_flag}, 2'b00);
        tick(3);
        irq_n = 1'b1;

        // R7/R10: NMI in running state
        exp_q.push_back('{nmi: 1'b1, vec: 16'h0066, bumped: 1'b0});
        nmi_pulse();
        done_pulse(1'b0, 1'b0);
        chk(ack_valid == 1, "R10 nmi ack in run", ack_valid, 1);
        tick(2);

        // R11: reset while halted
        fetch(8'h76);
        tick(2);
        chk(halt_n == 0, "R11 halted before reset", halt_n, 0);
        rst_n = 1'b0;
        tick(1);
        chk(halt_n == 1, "R11 reset releases", halt_n, 1);
        rst_n = 1'b1;
        tick(3);

        chk(exp_q.size() == 0, "R7 all expected acks seen", exp_q.size(), 0);
        report();
    end
endmodule